// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Pair with Hardware Flow Control

This block holds the two character queues of a 16550-class serial port: a receive queue whose entries carry a data byte plus three error flags, and a transmit queue of plain bytes. The register side of the port writes transmit bytes and reads received characters. The serializer side pushes received characters and requests the next transmit byte at each character boundary. A depth-mode input selects single-register behaviour (the reset-compatible mode), a 16-entry queue, or the full 64-entry queue. The receive trigger levels and the flow-control threshold scale with the selected mode.

Hardware flow control drives the request-to-send output from the receive fill level. It also withholds transmit bytes from the serializer while clear-to-send is low. A bypass input reroutes the queues to a parallel subsystem port. In bypass the subsystem writes the receive queue and reads the transmit queue directly, and the serializer ports have no effect. The level and interrupt-relevant flags behave the same way in both routings.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset both levels are 0, both overrun flags are 0, tx_empty is 1, rts is 1, tx_out_valid is 0 and the read data outputs are 0.
- R2: Capacity follows `mode`: 0 gives 1 entry, 1 gives 16 entries, and 2 or 3 give 64 entries. A push into a full queue is dropped, the level is left unchanged, and that queue's overrun flag is set. The overrun flag stays set until a FIFO clear.
- R3: Each queue returns entries in the order they were written. A host read updates host_rx_data/host_rx_err on the next cycle. A transmit pop presents the byte on tx_out_data with tx_out_valid high for exactly one cycle.
- R4: A pop from an empty queue leaves the level at 0 and keeps the previous read data. For the transmit queue it also leaves tx_out_valid low.
- R5: fifo_clr empties both queues and clears both overrun flags on the next cycle.
- R6: With auto_rts_en high, rts is low while rx_level ≥ 14 in mode 1, or rx_level ≥ 56 in modes 2/3, and is high again once the level falls below that threshold. In mode 0, or with auto_rts_en low, rts stays high.
- R7: Outside bypass, a ser_tx_req pops the transmit queue only if auto_cts_en is low or cts is high. A blocked request leaves the level unchanged and produces no tx_out_valid.
- R8: rx_trig_hit is high when rx_level ≥ the selected trigger. trig_sel values 0..3 give 1/4/8/14 in mode 1 and 1/16/32/56 in modes 2/3. Mode 0 always uses a trigger of 1.
- R9: With bypass_en high, sub_rx_wr pushes sub_rx_data with error flags 000, and sub_tx_rd pops the transmit queue regardless of cts. ser_rx_wr and ser_tx_req are ignored in bypass. With bypass_en low, sub_rx_wr and sub_tx_rd are ignored.
- R10: tx_empty is high exactly when tx_level is 0, in both routings.
- R11: A push and a pop in the same cycle on a full queue are both accepted, and the level is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Depth mode: 0 single, 1 sixteen, 2/3 sixty-four |
| trig_sel | input | 2 | Receive trigger level select |
| fifo_clr | input | 1 | Empty both queues, clear overruns |
| auto_rts_en | input | 1 | Enable level-driven rts |
| auto_cts_en | input | 1 | Enable cts gating of transmit starts |
| bypass_en | input | 1 | Route queues to the subsystem port |
| host_tx_wr | input | 1 | Host writes a transmit byte |
| host_tx_data | input | 8 | Transmit byte from host |
| host_rx_rd | input | 1 | Host reads a received character |
| host_rx_data | output | 8 | Last character read by host |
| host_rx_err | output | 3 | Error flags of last character read |
| ser_rx_wr | input | 1 | Serializer pushes a received character |
| ser_rx_data | input | 8 | Received data byte |
| ser_rx_err | input | 3 | Received error flags |
| ser_tx_req | input | 1 | Serializer at a character boundary asks for a byte |
| sub_rx_wr | input | 1 | Subsystem writes into the receive queue (bypass) |
| sub_rx_data | input | 8 | Subsystem receive byte |
| sub_tx_rd | input | 1 | Subsystem reads from the transmit queue (bypass) |
| tx_out_valid | output | 1 | One-cycle pulse: tx_out_data holds a popped byte |
| tx_out_data | output | 8 | Last popped transmit byte |
| cts | input | 1 | Clear-to-send, high = peer ready |
| rts | output | 1 | Request-to-send, high = asserted |
| rx_level | output | 7 | Receive queue fill level |
| tx_level | output | 7 | Transmit queue fill level |
| rx_trig_hit | output | 1 | Receive level at or above trigger |
| tx_empty | output | 1 | Transmit queue empty |
| rx_overrun | output | 1 | Sticky receive push-to-full flag |
| tx_overrun | output | 1 | Sticky transmit push-to-full flag |

## Verification
A wrong pointer or level register shows on rx_level/tx_level in the cycle after the faulty push or pop. It then spreads to rts and rx_trig_hit in the same cycle. A corrupted storage word or a skipped pointer only appears when that entry is read back, so the bench fills each queue to capacity and drains it completely in every mode. A mis-scaled threshold is exposed by sweeping every trigger select at every fill level, and by checking rts across the whole fill and drain.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
    localparam int DATA_W     = 8;
    localparam int ERR_W      = 3;
    localparam int FIFO_DEPTH = 64;
    localparam int STD_DEPTH  = 16;
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);
    localparam int RTS_STD    = 14;
    localparam int RTS_EXT    = 56;

    typedef enum logic [1:0] {
        DM_SINGLE = 2'd0,
        DM_STD    = 2'd1,
        DM_EXT    = 2'd2,
        DM_EXT_B  = 2'd3
    } depth_mode_e;

    typedef struct packed {
        logic [ERR_W-1:0]  err;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    function automatic logic [LVL_W-1:0] mode_cap(input logic [1:0] m);
        case (m)
            DM_SINGLE: return LVL_W'(1);
            DM_STD:    return LVL_W'(STD_DEPTH);
            default:   return LVL_W'(FIFO_DEPTH);
        endcase
    endfunction

    function automatic logic [LVL_W-1:0] rts_limit(input logic [1:0] m);
        return (m == DM_STD) ? LVL_W'(RTS_STD) : LVL_W'(RTS_EXT);
    endfunction

    function automatic logic [LVL_W-1:0] trig_level(input logic [1:0] m, input logic [1:0] s);
        if (m == DM_SINGLE || s == 2'd0) return LVL_W'(1);
        if (m == DM_STD) begin
            case (s)
                2'd1:    return LVL_W'(4);
                2'd2:    return LVL_W'(8);
                default: return LVL_W'(RTS_STD);
            endcase
        end
        case (s)
            2'd1:    return LVL_W'(STD_DEPTH);
            2'd2:    return LVL_W'(2 * STD_DEPTH);
            default: return LVL_W'(RTS_EXT);
        endcase
    endfunction
endpackage

// File: rtl/uart_fifo_store.sv
module uart_fifo_store #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int LW   = $clog2(DEPTH + 1),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [LW-1:0] cap,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  rd_data,
    output logic          rd_valid,
    output logic [LW-1:0] level,
    output logic          overrun
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          pop_ok, push_ok;

    assign pop_ok  = pop && (level != '0);
    assign push_ok = push && ((level < cap) || pop_ok);

    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            overrun  <= 1'b0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else if (clr) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            overrun  <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + PW'(1);
            if (pop_ok) begin
                rd_ptr  <= rd_ptr + PW'(1);
                rd_data <= mem[rd_ptr];
            end
            rd_valid <= pop_ok;
            level    <= level + LW'(push_ok) - LW'(pop_ok);
            if (push && !push_ok) overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
    import uart_fifo_pkg::*;
(
    input  logic [1:0]       mode,
    input  logic [1:0]       trig_sel,
    input  logic             auto_rts_en,
    input  logic             auto_cts_en,
    input  logic             bypass_en,
    input  logic             cts,
    input  logic             ser_tx_req,
    input  logic             sub_tx_rd,
    input  logic [LVL_W-1:0] rx_level,
    output logic             rts,
    output logic             rx_trig_hit,
    output logic             tx_pop
);
    logic has_limit;

    always_comb begin
        has_limit   = auto_rts_en && (mode != DM_SINGLE);
        rts         = !(has_limit && (rx_level >= rts_limit(mode)));
        rx_trig_hit = rx_level >= trig_level(mode, trig_sel);
        if (bypass_en) tx_pop = sub_tx_rd;
        else           tx_pop = ser_tx_req && (!auto_cts_en || cts);
    end
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
    import uart_fifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic [1:0]       trig_sel,
    input  logic             fifo_clr,
    input  logic             auto_rts_en,
    input  logic             auto_cts_en,
    input  logic             bypass_en,
    input  logic             host_tx_wr,
    input  logic [7:0]       host_tx_data,
    input  logic             host_rx_rd,
    output logic [7:0]       host_rx_data,
    output logic [2:0]       host_rx_err,
    input  logic             ser_rx_wr,
    input  logic [7:0]       ser_rx_data,
    input  logic [2:0]       ser_rx_err,
    input  logic             ser_tx_req,
    input  logic             sub_rx_wr,
    input  logic [7:0]       sub_rx_data,
    input  logic             sub_tx_rd,
    output logic             tx_out_valid,
    output logic [7:0]       tx_out_data,
    input  logic             cts,
    output logic             rts,
    output logic [6:0]       rx_level,
    output logic [6:0]       tx_level,
    output logic             rx_trig_hit,
    output logic             tx_empty,
    output logic             rx_overrun,
    output logic             tx_overrun
);
    localparam int RX_W = DATA_W + ERR_W;

    rx_entry_t        rx_in, rx_out;
    logic             rx_push, tx_pop, rx_unused_valid;
    logic [LVL_W-1:0] cap, rx_lvl, tx_lvl;

    assign cap = mode_cap(mode);

    always_comb begin
        if (bypass_en) begin
            rx_push    = sub_rx_wr;
            rx_in.data = sub_rx_data;
            rx_in.err  = '0;
        end else begin
            rx_push    = ser_rx_wr;
            rx_in.data = ser_rx_data;
            rx_in.err  = ser_rx_err;
        end
    end

    uart_fifo_store #(.W(RX_W), .DEPTH(FIFO_DEPTH)) u_rx_q (
        .clk(clk), .rst(rst), .clr(fifo_clr), .cap(cap),
        .push(rx_push), .push_data(rx_in), .pop(host_rx_rd),
        .rd_data(rx_out), .rd_valid(rx_unused_valid),
        .level(rx_lvl), .overrun(rx_overrun)
    );

    uart_fifo_store #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_q (
        .clk(clk), .rst(rst), .clr(fifo_clr), .cap(cap),
        .push(host_tx_wr), .push_data(host_tx_data), .pop(tx_pop),
        .rd_data(tx_out_data), .rd_valid(tx_out_valid),
        .level(tx_lvl), .overrun(tx_overrun)
    );

    uart_flow_ctrl u_flow (
        .mode(mode), .trig_sel(trig_sel), .auto_rts_en(auto_rts_en),
        .auto_cts_en(auto_cts_en), .bypass_en(bypass_en), .cts(cts),
        .ser_tx_req(ser_tx_req), .sub_tx_rd(sub_tx_rd), .rx_level(rx_lvl),
        .rts(rts), .rx_trig_hit(rx_trig_hit), .tx_pop(tx_pop)
    );

    assign host_rx_data = rx_out.data;
    assign host_rx_err  = rx_out.err;
    assign rx_level     = rx_lvl;
    assign tx_level     = tx_lvl;
    assign tx_empty     = (tx_lvl == '0);
endmodule

// File: rtl/uart_fifo_pair_chk.sv
module uart_fifo_pair_chk
    import uart_fifo_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       fifo_clr,
    input logic       auto_rts_en,
    input logic       bypass_en,
    input logic       auto_cts_en,
    input logic       cts,
    input logic       host_rx_rd,
    input logic       sub_rx_wr,
    input logic [7:0] host_rx_data,
    input logic       tx_out_valid,
    input logic       rts,
    input logic [6:0] rx_level,
    input logic [6:0] tx_level,
    input logic       rx_overrun
);
    assert_full_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (rx_level == mode_cap(mode) && !host_rx_rd && !fifo_clr) |=> rx_level == $past(rx_level));

    assert_overrun_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        (rx_overrun && !fifo_clr) |=> rx_overrun);

    assert_empty_read_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_level == 0 && !fifo_clr) |=> $stable(host_rx_data));

    assert_clear_empties_R5: assert property (@(posedge clk) disable iff (rst)
        fifo_clr |=> (rx_level == 0 && tx_level == 0 && !rx_overrun));

    assert_rts_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !auto_rts_en |-> rts);

    assert_rts_ext_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (auto_rts_en && mode[1] && rx_level >= 56) |-> !rts);

    assert_cts_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (!bypass_en && auto_cts_en && !cts) |=> !tx_out_valid);

    assert_bypass_no_push_R9: assert property (@(posedge clk) disable iff (rst)
        (bypass_en && !sub_rx_wr && !host_rx_rd && !fifo_clr) |=> rx_level == $past(rx_level));
endmodule

bind uart_fifo_pair uart_fifo_pair_chk u_chk (.*);

// File: tb/uart_fifo_pair_tb.sv
module uart_fifo_pair_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst = 1;
    logic [1:0] mode = 0, trig_sel = 0;
    logic fifo_clr = 0, auto_rts_en = 0, auto_cts_en = 0, bypass_en = 0;
    logic host_tx_wr = 0, host_rx_rd = 0, ser_rx_wr = 0, ser_tx_req = 0;
    logic sub_rx_wr = 0, sub_tx_rd = 0, cts = 0;
    logic [7:0] host_tx_data = 0, ser_rx_data = 0, sub_rx_data = 0;
    logic [2:0] ser_rx_err = 0;
    logic [7:0] host_rx_data, tx_out_data;
    logic [2:0] host_rx_err;
    logic tx_out_valid, rts, rx_trig_hit, tx_empty, rx_overrun, tx_overrun;
    logic [6:0] rx_level, tx_level;

    int errors = 0, checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_fifo_pair u_dut (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic int exp_cap(input int m);
        return (m == 0) ? 1 : (m == 1) ? 16 : 64;
    endfunction

    function automatic int exp_trig(input int m, input int s);
        if (m == 0 || s == 0) return 1;
        if (m == 1) return (s == 3) ? 14 : 4 * s;
        return (s == 3) ? 56 : 16 * s;
    endfunction

    function automatic int exp_rts(input int m, input int lvl);
        if (m == 0) return 1;
        return (lvl >= ((m == 1) ? 14 : 56)) ? 0 : 1;
    endfunction

    task automatic pulse_clr();
        fifo_clr = 1; step(); fifo_clr = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int last;
        repeat (3) step();
        rst = 0;
        // R1 reset state
        check("R1 rx_level", rx_level, 0);
        check("R1 tx_level", tx_level, 0);
        check("R1 overruns", {rx_overrun, tx_overrun}, 0);
        check("R1 tx_empty", tx_empty, 1);
        check("R1 rts", rts, 1);
        check("R1 tx_out_valid", tx_out_valid, 0);
        check("R1 read data", {host_rx_data, host_rx_err, tx_out_data}, 0);

        // R2 R3 R4 R6 R8 receive sweep in every mode
        for (int m = 0; m < 3; m++) begin
            int cap;
            cap = exp_cap(m);
            mode = 2'(m); auto_rts_en = 1;
            pulse_clr();
            for (int i = 0; i < cap + 2; i++) begin
                int lvl;
                ser_rx_wr = 1; ser_rx_data = 8'((i * 7 + m) & 255); ser_rx_err = 3'(i % 8);
                step(); ser_rx_wr = 0;
                lvl = (i + 1 < cap) ? i + 1 : cap;
                check("R2 rx level on fill", rx_level, lvl);
                check("R2 rx overrun", rx_overrun, (i + 1 > cap) ? 1 : 0);
                check("R6 rts on fill", rts, exp_rts(m, lvl));
                for (int s = 0; s < 4; s++) begin
                    trig_sel = 2'(s); #1;
                    check("R8 trigger", rx_trig_hit, (lvl >= exp_trig(m, s)) ? 1 : 0);
                end
            end
            for (int i = 0; i < cap; i++) begin
                host_rx_rd = 1; step(); host_rx_rd = 0;
                check("R3 rx data order", host_rx_data, (i * 7 + m) & 255);
                check("R3 rx err flags", host_rx_err, i % 8);
                check("R3 rx level drain", rx_level, cap - 1 - i);
                check("R6 rts on drain", rts, exp_rts(m, cap - 1 - i));
                check("R2 overrun sticky", rx_overrun, 1);
            end
            last = ((cap - 1) * 7 + m) & 255;
            host_rx_rd = 1; step(); host_rx_rd = 0;
            check("R4 empty rx read data", host_rx_data, last);
            check("R4 empty rx level", rx_level, 0);
            pulse_clr();
            check("R5 clear overrun", rx_overrun, 0);
        end

        // R6 disabled: fill sixteen mode without auto_rts_en
        mode = 1; auto_rts_en = 0; pulse_clr();
        for (int i = 0; i < 16; i++) begin
            ser_rx_wr = 1; step(); ser_rx_wr = 0;
        end
        check("R6 rts stays high when disabled", rts, 1);
        // R5 clear both queues
        host_tx_wr = 1; step(); host_tx_wr = 0;
        pulse_clr();
        check("R5 clear rx", rx_level, 0);
        check("R5 clear tx", tx_level, 0);

        // R7 R3 R10 transmit with cts gating
        mode = 2; auto_cts_en = 1; cts = 0; pulse_clr();
        for (int i = 0; i < 65; i++) begin
            host_tx_wr = 1; host_tx_data = 8'(255 - i); step(); host_tx_wr = 0;
            check("R2 tx level", tx_level, (i + 1 < 64) ? i + 1 : 64);
            check("R10 tx_empty filled", tx_empty, 0);
        end
        check("R2 tx overrun", tx_overrun, 1);
        for (int k = 0; k < 3; k++) begin
            ser_tx_req = 1; step(); ser_tx_req = 0;
            check("R7 blocked no valid", tx_out_valid, 0);
            check("R7 blocked level", tx_level, 64);
        end
        cts = 1;
        for (int i = 0; i < 64; i++) begin
            ser_tx_req = 1; step(); ser_tx_req = 0;
            check("R3 tx valid", tx_out_valid, 1);
            check("R3 tx data order", tx_out_data, 255 - i);
            check("R7 tx level", tx_level, 63 - i);
            step();
            check("R3 tx valid one cycle", tx_out_valid, 0);
        end
        check("R10 tx_empty drained", tx_empty, 1);
        ser_tx_req = 1; step(); ser_tx_req = 0;
        check("R4 empty tx no valid", tx_out_valid, 0);
        check("R4 empty tx data held", tx_out_data, 192);

        // R9 bypass routing
        mode = 1; bypass_en = 1; cts = 1; pulse_clr();
        ser_rx_wr = 1; step(); ser_rx_wr = 0;
        check("R9 ser_rx ignored in bypass", rx_level, 0);
        sub_rx_wr = 1; sub_rx_data = 8'hA5; step(); sub_rx_wr = 0;
        check("R9 sub push", rx_level, 1);
        host_rx_rd = 1; step(); host_rx_rd = 0;
        check("R9 sub data", host_rx_data, 8'hA5);
        check("R9 sub err zero", host_rx_err, 0);
        host_tx_wr = 1; host_tx_data = 8'h3C; step(); host_tx_wr = 0;
        ser_tx_req = 1; step(); ser_tx_req = 0;
        check("R9 ser_tx_req ignored", tx_level, 1);
        check("R9 ser_tx_req no valid", tx_out_valid, 0);
        cts = 0;
        sub_tx_rd = 1; step(); sub_tx_rd = 0;
        check("R9 sub pop valid", tx_out_valid, 1);
        check("R9 sub pop data", tx_out_data, 8'h3C);
        check("R10 tx_empty bypass", tx_empty, 1);
        bypass_en = 0;
        sub_rx_wr = 1; step(); sub_rx_wr = 0;
        check("R9 sub ignored outside bypass", rx_level, 0);
        host_tx_wr = 1; step(); host_tx_wr = 0;
        sub_tx_rd = 1; step(); sub_tx_rd = 0;
        check("R9 sub_tx_rd ignored", tx_level, 1);

        // R11 simultaneous push and pop at full (single mode)
        mode = 0; auto_cts_en = 0; pulse_clr();
        ser_rx_wr = 1; ser_rx_data = 8'h11; ser_rx_err = 3'd5; step();
        ser_rx_data = 8'h22; ser_rx_err = 3'd2; host_rx_rd = 1; step();
        ser_rx_wr = 0; host_rx_rd = 0;
        check("R11 level kept", rx_level, 1);
        check("R11 first out", host_rx_data, 8'h11);
        check("R11 no overrun", rx_overrun, 0);
        host_rx_rd = 1; step(); host_rx_rd = 0;
        check("R11 second out", host_rx_data, 8'h22);
        check("R11 second err", host_rx_err, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule